// File: doc/BRIEF.md
# Set-Associative Branch Target Buffer

This block sits beside the decode stage of a dual-pipe processor and remembers the branches that have been taken. It holds 256 entries arranged as 64 sets of 4 ways. Each entry keeps a valid flag, an address tag, the stored branch target and a 2-bit saturating history counter. Two lookup ports, one per decode pipe, each take the fetch address of a branch. In the same cycle each port returns a hit flag, a taken/not-taken prediction and the predicted target. An address that is not in the buffer is always predicted not taken, whatever the kind of branch.

The execute stage reports every resolved branch on a single update port: the fetch address, the outcome and the actual target. A branch that is already stored has its counter trained. A taken outcome also rewrites its target. A branch that is not stored gets a new entry only when it resolved taken, and that entry starts strongly taken. The new entry goes into the lowest-numbered free way of its set. When the set is full it replaces the way chosen by a per-set tree pseudo-LRU. A synchronous flush input and the asynchronous reset both empty the whole buffer.

Top module: `branch_target_buf`

## Requirements
- R1: Set index is fetch address bits [7:2] and tag is bits [31:8]. Bits [1:0] do not take part in matching, so two addresses that differ only there hit the same entry.
- R2: The two lookup ports are independent and both answer combinationally in the same cycle from the same stored state.
- R3: On a miss a port drives hit=0, taken=0 and target=0.
- R4: On a hit the port drives hit=1 and the stored target. Taken is the counter's upper bit: 2'b11 (strong taken) and 2'b10 (weak taken) predict taken, 2'b01 (weak not taken) and 2'b00 (strong not taken) predict not taken.
- R5: An update that misses and reports taken allocates an entry with the update's tag and target and counter 2'b11.
- R6: An update that misses and reports not taken leaves the buffer unchanged.
- R7: An update that hits increments the counter on taken, saturating at 2'b11, and decrements it on not taken, saturating at 2'b00.
- R8: An update that hits and reports taken replaces the stored target. A hit reported not taken keeps the old target.
- R9: Allocation fills the lowest-numbered invalid way of the set when one exists.
- R10: In a full set, allocation replaces the way named by a 3-bit tree pseudo-LRU. Bit 0 picks the pair (0: ways 0/1, 1: ways 2/3), bit 1 picks within ways 0/1 (0: way 0), and bit 2 picks within ways 2/3 (0: way 2). Every update that hits or allocates in the set points these bits away from the way it used. Lookups do not change them, and reset or flush sets them to 0.
- R11: flush_i invalidates every entry from the next cycle and takes priority over an update in the same cycle.
- R12: rst_ni low invalidates every entry at once, without waiting for a clock edge.
- R13: Updates and flushes change lookup results only from the cycle after they are presented. With neither present, a repeated lookup gives the same result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| flush_i | input | 1 | Invalidate all entries |
| lk_pc_i | input | NUM_PORTS x ADDR_W | Fetch address per lookup port |
| lk_hit_o | output | NUM_PORTS | Entry found per port |
| lk_taken_o | output | NUM_PORTS | Taken prediction per port |
| lk_target_o | output | NUM_PORTS x ADDR_W | Predicted target per port |
| upd_valid_i | input | 1 | Resolved branch reported |
| upd_pc_i | input | ADDR_W | Fetch address of resolved branch |
| upd_taken_i | input | 1 | Resolved outcome |
| upd_target_i | input | ADDR_W | Resolved target address |

## Verification
Lookup outputs are combinational, so they are due in the same cycle as the address. Updates and flushes show up in lookups one rising edge later, and reset shows up at once. The bench drives inputs at the falling edge and samples the ports 1 ns later, which compares them against the model state from before the coming edge. It applies the model update only after that rising edge. The counter walk, the invalid-way fill and the pseudo-LRU victim order are checked as directed sequences, and flush and asynchronous reset are each checked in the cycle they are due. Random traffic on a small pool of tags and sets then keeps the sets full and checks both ports against the model every cycle.

// File: rtl/bt_pkg.sv
package bt_pkg;
  typedef logic [1:0] ctr_t;

  localparam ctr_t CTR_STRONG_T = 2'b11;

  function automatic ctr_t ctr_train(input ctr_t c, input logic taken);
    if (taken) return (c == 2'b11) ? c : c + 2'b01;
    else       return (c == 2'b00) ? c : c - 2'b01;
  endfunction
endpackage

// File: rtl/bt_way_match.sv
module bt_way_match import bt_pkg::*; #(
  parameter int unsigned NUM_WAYS = 4,
  parameter int unsigned TAG_W    = 24,
  parameter int unsigned ADDR_W   = 32,
  localparam int unsigned WAY_W   = $clog2(NUM_WAYS)
) (
  input  logic [NUM_WAYS-1:0]             valid_i,
  input  logic [NUM_WAYS-1:0][TAG_W-1:0]  tags_i,
  input  logic [NUM_WAYS-1:0][ADDR_W-1:0] tgts_i,
  input  ctr_t [NUM_WAYS-1:0]             ctrs_i,
  input  logic [TAG_W-1:0]                tag_i,
  output logic                            hit_o,
  output logic [WAY_W-1:0]                way_o,
  output logic [ADDR_W-1:0]               tgt_o,
  output ctr_t                            ctr_o
);
  // tags are unique per set, so first match is the only match
  always_comb begin
    hit_o = 1'b0;
    way_o = '0;
    tgt_o = '0;
    ctr_o = '0;
    for (int w = 0; w < NUM_WAYS; w++) begin
      if (!hit_o && valid_i[w] && tags_i[w] == tag_i) begin
        hit_o = 1'b1;
        way_o = WAY_W'(w);
        tgt_o = tgts_i[w];
        ctr_o = ctrs_i[w];
      end
    end
  end
endmodule

// File: rtl/bt_plru_tree.sv
module bt_plru_tree #(
  parameter int unsigned NUM_WAYS = 4,
  localparam int unsigned WAY_W   = $clog2(NUM_WAYS)
) (
  input  logic [NUM_WAYS-2:0] bits_i,
  input  logic [WAY_W-1:0]    touch_i,
  output logic [WAY_W-1:0]    victim_o,
  output logic [NUM_WAYS-2:0] bits_o
);
  // heap layout: node n (root = 1) stored at bit n-1
  always_comb begin
    int unsigned node;
    node = 1;
    for (int l = 0; l < WAY_W; l++) node = 2 * node + int'(bits_i[node-1]);
    victim_o = WAY_W'(node - NUM_WAYS);
  end

  always_comb begin
    int unsigned node;
    bits_o = bits_i;
    node   = 1;
    for (int l = 0; l < WAY_W; l++) begin
      bits_o[node-1] = ~touch_i[WAY_W-1-l];
      node = 2 * node + int'(touch_i[WAY_W-1-l]);
    end
  end
endmodule

// File: rtl/branch_target_buf.sv
module branch_target_buf import bt_pkg::*; #(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned NUM_SETS  = 64,
  parameter int unsigned NUM_WAYS  = 4,
  parameter int unsigned NUM_PORTS = 2,
  parameter int unsigned IDX_LSB   = 2
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              flush_i,
  input  logic [NUM_PORTS-1:0][ADDR_W-1:0]  lk_pc_i,
  output logic [NUM_PORTS-1:0]              lk_hit_o,
  output logic [NUM_PORTS-1:0]              lk_taken_o,
  output logic [NUM_PORTS-1:0][ADDR_W-1:0]  lk_target_o,
  input  logic                              upd_valid_i,
  input  logic [ADDR_W-1:0]                 upd_pc_i,
  input  logic                              upd_taken_i,
  input  logic [ADDR_W-1:0]                 upd_target_i
);
  localparam int unsigned IDX_W  = $clog2(NUM_SETS);
  localparam int unsigned WAY_W  = $clog2(NUM_WAYS);
  localparam int unsigned TAG_W  = ADDR_W - IDX_W - IDX_LSB;
  localparam int unsigned PLRU_W = NUM_WAYS - 1;

  logic [NUM_SETS-1:0][NUM_WAYS-1:0]             valid_q;
  logic [NUM_SETS-1:0][NUM_WAYS-1:0][TAG_W-1:0]  tag_q;
  logic [NUM_SETS-1:0][NUM_WAYS-1:0][ADDR_W-1:0] tgt_q;
  ctr_t [NUM_SETS-1:0][NUM_WAYS-1:0]             ctr_q;
  logic [NUM_SETS-1:0][PLRU_W-1:0]               plru_q;

  // lookup ports
  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_lk
    logic [IDX_W-1:0] idx;
    logic [TAG_W-1:0] tag;
    logic [WAY_W-1:0] way_unused;
    ctr_t             ctr;

    assign idx = lk_pc_i[p][IDX_LSB +: IDX_W];
    assign tag = lk_pc_i[p][ADDR_W-1 -: TAG_W];

    bt_way_match #(.NUM_WAYS(NUM_WAYS), .TAG_W(TAG_W), .ADDR_W(ADDR_W)) i_match (
      .valid_i (valid_q[idx]),
      .tags_i  (tag_q[idx]),
      .tgts_i  (tgt_q[idx]),
      .ctrs_i  (ctr_q[idx]),
      .tag_i   (tag),
      .hit_o   (lk_hit_o[p]),
      .way_o   (way_unused),
      .tgt_o   (lk_target_o[p]),
      .ctr_o   (ctr)
    );

    assign lk_taken_o[p] = lk_hit_o[p] & ctr[1];
  end

  // update port
  logic [IDX_W-1:0]  u_idx;
  logic [TAG_W-1:0]  u_tag;
  logic              u_hit;
  logic [WAY_W-1:0]  u_way;
  logic [ADDR_W-1:0] u_tgt_unused;
  ctr_t              u_ctr;
  logic              u_has_inv;
  logic [WAY_W-1:0]  u_inv_way;
  logic [WAY_W-1:0]  u_victim;
  logic [WAY_W-1:0]  wr_way;
  logic [PLRU_W-1:0] plru_nxt;
  logic              alloc, train;

  assign u_idx = upd_pc_i[IDX_LSB +: IDX_W];
  assign u_tag = upd_pc_i[ADDR_W-1 -: TAG_W];

  bt_way_match #(.NUM_WAYS(NUM_WAYS), .TAG_W(TAG_W), .ADDR_W(ADDR_W)) i_upd_match (
    .valid_i (valid_q[u_idx]),
    .tags_i  (tag_q[u_idx]),
    .tgts_i  (tgt_q[u_idx]),
    .ctrs_i  (ctr_q[u_idx]),
    .tag_i   (u_tag),
    .hit_o   (u_hit),
    .way_o   (u_way),
    .tgt_o   (u_tgt_unused),
    .ctr_o   (u_ctr)
  );

  // lowest-numbered free way
  always_comb begin
    u_has_inv = 1'b0;
    u_inv_way = '0;
    for (int w = NUM_WAYS - 1; w >= 0; w--) begin
      if (!valid_q[u_idx][w]) begin
        u_has_inv = 1'b1;
        u_inv_way = WAY_W'(w);
      end
    end
  end

  bt_plru_tree #(.NUM_WAYS(NUM_WAYS)) i_plru (
    .bits_i   (plru_q[u_idx]),
    .touch_i  (wr_way),
    .victim_o (u_victim),
    .bits_o   (plru_nxt)
  );

  assign alloc  = upd_valid_i & ~u_hit & upd_taken_i;
  assign train  = upd_valid_i & u_hit;
  assign wr_way = u_hit ? u_way : (u_has_inv ? u_inv_way : u_victim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
      ctr_q   <= '0;
      plru_q  <= '0;
    end else if (flush_i) begin
      valid_q <= '0;
      plru_q  <= '0;
    end else begin
      if (alloc || train) plru_q[u_idx] <= plru_nxt;
      if (alloc) begin
        valid_q[u_idx][wr_way] <= 1'b1;
        ctr_q[u_idx][wr_way]   <= CTR_STRONG_T;
      end else if (train) begin
        ctr_q[u_idx][wr_way]   <= ctr_train(u_ctr, upd_taken_i);
      end
    end
  end

  // payload needs no reset: guarded by valid_q
  always_ff @(posedge clk_i) begin
    if (!flush_i && (alloc || (train && upd_taken_i))) begin
      tgt_q[u_idx][wr_way] <= upd_target_i;
      if (alloc) tag_q[u_idx][wr_way] <= u_tag;
    end
  end
endmodule

// File: rtl/bt_checker.sv
module bt_checker #(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned NUM_PORTS = 2
) (
  input logic                             clk_i,
  input logic                             rst_ni,
  input logic                             flush_i,
  input logic [NUM_PORTS-1:0][ADDR_W-1:0] lk_pc_i,
  input logic [NUM_PORTS-1:0]             lk_hit_o,
  input logic [NUM_PORTS-1:0]             lk_taken_o,
  input logic [NUM_PORTS-1:0][ADDR_W-1:0] lk_target_o,
  input logic                             upd_valid_i,
  input logic [ADDR_W-1:0]                upd_pc_i,
  input logic                             upd_taken_i,
  input logic [ADDR_W-1:0]                upd_target_i
);
  assert_flush_clears_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (lk_hit_o == '0));

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    assert_miss_not_taken_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !lk_hit_o[p] |-> (!lk_taken_o[p] && lk_target_o[p] == '0));

    assert_taken_upd_visible_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (upd_valid_i && upd_taken_i && !flush_i) |=>
        (lk_pc_i[p] != $past(upd_pc_i) ||
         (lk_hit_o[p] && lk_target_o[p] == $past(upd_target_i))));

    assert_quiet_stable_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!upd_valid_i && !flush_i) |=>
        (lk_pc_i[p] != $past(lk_pc_i[p]) ||
         (lk_hit_o[p] == $past(lk_hit_o[p]) && lk_taken_o[p] == $past(lk_taken_o[p]) &&
          lk_target_o[p] == $past(lk_target_o[p]))));
  end

  if (NUM_PORTS > 1) begin : g_dual
    assert_ports_agree_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (lk_pc_i[0] == lk_pc_i[1]) |->
        (lk_hit_o[0] == lk_hit_o[1] && lk_taken_o[0] == lk_taken_o[1] &&
         lk_target_o[0] == lk_target_o[1]));
  end
endmodule

bind branch_target_buf bt_checker #(.ADDR_W(ADDR_W), .NUM_PORTS(NUM_PORTS)) i_bt_checker (.*);

// File: tb/test_branch_target_buf.sv
`timescale 1ns/1ps
module test_branch_target_buf;
  logic             clk = 1'b0;
  logic             rst_n;
  logic             flush;
  logic [1:0][31:0] lk_pc;
  logic [1:0]       lk_hit, lk_taken;
  logic [1:0][31:0] lk_target;
  logic             upd_valid, upd_taken;
  logic [31:0]      upd_pc, upd_target;

  int n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;

  branch_target_buf i_branch_target_buf (
    .clk_i(clk), .rst_ni(rst_n), .flush_i(flush),
    .lk_pc_i(lk_pc), .lk_hit_o(lk_hit), .lk_taken_o(lk_taken), .lk_target_o(lk_target),
    .upd_valid_i(upd_valid), .upd_pc_i(upd_pc), .upd_taken_i(upd_taken),
    .upd_target_i(upd_target)
  );

  // reference model
  bit          m_valid [64][4];
  logic [23:0] m_tag   [64][4];
  logic [31:0] m_tgt   [64][4];
  logic [1:0]  m_ctr   [64][4];
  logic [2:0]  m_plru  [64];

  task automatic m_clear();
    foreach (m_valid[s, w]) m_valid[s][w] = 0;
    foreach (m_plru[s]) m_plru[s] = 3'b000;
  endtask

  function automatic int m_find(logic [31:0] pc);
    for (int w = 0; w < 4; w++)
      if (m_valid[pc[7:2]][w] && m_tag[pc[7:2]][w] == pc[31:8]) return w;
    return -1;
  endfunction

  function automatic int m_victim(logic [2:0] b);
    return b[0] ? (b[2] ? 3 : 2) : (b[1] ? 1 : 0);
  endfunction

  task automatic m_touch(int s, int w);
    m_plru[s][0] = (w < 2);
    if (w < 2) m_plru[s][1] = (w == 0);
    else       m_plru[s][2] = (w == 2);
  endtask

  task automatic m_update(logic [31:0] pc, bit taken, logic [31:0] tgt);
    int s, w;
    s = pc[7:2];
    w = m_find(pc);
    if (w >= 0) begin
      if (taken) begin
        if (m_ctr[s][w] != 2'b11) m_ctr[s][w]++;
        m_tgt[s][w] = tgt;
      end else if (m_ctr[s][w] != 2'b00) m_ctr[s][w]--;
      m_touch(s, w);
    end else if (taken) begin
      w = -1;
      for (int k = 3; k >= 0; k--) if (!m_valid[s][k]) w = k;
      if (w < 0) w = m_victim(m_plru[s]);
      m_valid[s][w] = 1; m_tag[s][w] = pc[31:8]; m_tgt[s][w] = tgt; m_ctr[s][w] = 2'b11;
      m_touch(s, w);
    end
  endtask

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic expect_lk(int p, bit h, bit t, logic [31:0] tg, string req);
    chk(req, {30'd0, lk_hit[p], lk_taken[p], lk_target[p]}, {30'd0, h, t, tg});
  endtask

  task automatic drive(logic [31:0] p0, logic [31:0] p1, bit uv, logic [31:0] upc,
                       bit ut, logic [31:0] utg, bit fl);
    @(negedge clk);
    lk_pc[0] = p0; lk_pc[1] = p1;
    upd_valid = uv; upd_pc = upc; upd_taken = ut; upd_target = utg; flush = fl;
    #1;
  endtask

  task automatic auto_check();
    for (int p = 0; p < 2; p++) begin
      int w;
      w = m_find(lk_pc[p]);
      if (w < 0) expect_lk(p, 0, 0, 32'd0, "R3 miss");
      else expect_lk(p, 1, m_ctr[lk_pc[p][7:2]][w][1], m_tgt[lk_pc[p][7:2]][w], "R4 hit");
    end
  endtask

  task automatic commit();
    @(posedge clk);
    if (flush) m_clear();
    else if (upd_valid) m_update(upd_pc, upd_taken, upd_target);
  endtask

  task automatic step(logic [31:0] p0, logic [31:0] p1, bit uv, logic [31:0] upc,
                      bit ut, logic [31:0] utg, bit fl);
    drive(p0, p1, uv, upc, ut, utg, fl);
    auto_check();
    commit();
  endtask

  function automatic logic [31:0] set5(int t);
    return (t << 8) | (5 << 2);
  endfunction

  bit done = 0;

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] a, b, t1, t2;
    bit o [6];
    bit e [6];
    a = 32'h0000_1234; b = 32'h0000_5678; t1 = 32'hCAFE_0010; t2 = 32'hBEEF_0020;
    o = '{0, 0, 0, 0, 1, 1};
    e = '{1, 0, 0, 0, 0, 1};
    void'($urandom(32'd20240611));
    rst_n = 0; flush = 0; upd_valid = 0; upd_pc = 0; upd_taken = 0; upd_target = 0;
    lk_pc[0] = a; lk_pc[1] = b;
    m_clear();
    repeat (3) @(negedge clk);
    #1;
    expect_lk(0, 0, 0, 0, "R12 reset"); expect_lk(1, 0, 0, 0, "R12 reset");
    @(negedge clk); rst_n = 1;

    // R6: not-taken miss does not allocate
    step(a, a, 1, a, 0, t1, 0);
    drive(a, a, 0, 0, 0, 0, 0); expect_lk(0, 0, 0, 0, "R6"); commit();

    // R5/R13: taken miss allocates, visible next cycle only
    drive(a, a, 1, a, 1, t1, 0); expect_lk(0, 0, 0, 0, "R13"); commit();
    drive(a, a | 32'h3, 0, 0, 0, 0, 0);
    expect_lk(0, 1, 1, t1, "R5"); expect_lk(1, 1, 1, t1, "R1 low bits"); commit();

    // R1/R2: tag and index separation, ports independent
    drive(a, a ^ 32'h100, 0, 0, 0, 0, 0);
    expect_lk(0, 1, 1, t1, "R2"); expect_lk(1, 0, 0, 0, "R1 tag"); commit();
    drive(a ^ 32'h4, a, 0, 0, 0, 0, 0);
    expect_lk(0, 0, 0, 0, "R1 index"); expect_lk(1, 1, 1, t1, "R2"); commit();

    // R7: counter walk 11->10->01->00->00->01->10
    for (int i = 0; i < 6; i++) begin
      step(a, b, 1, a, o[i], t1, 0);
      drive(a, b, 0, 0, 0, 0, 0); expect_lk(0, 1, e[i], t1, "R7"); commit();
    end

    // R8: target kept on not taken, rewritten on taken
    step(a, b, 1, a, 0, t2, 0);
    drive(a, b, 0, 0, 0, 0, 0); expect_lk(0, 1, 0, t1, "R8 keep"); commit();
    step(a, b, 1, a, 1, t2, 0);
    drive(a, b, 0, 0, 0, 0, 0); expect_lk(0, 1, 1, t2, "R8 rewrite"); commit();

    // R9/R10: fill free ways, then pseudo-LRU victims
    step(a, b, 0, 0, 0, 0, 1);
    for (int t = 1; t <= 4; t++) step(a, b, 1, set5(t), 1, 32'h1000 + t, 0);
    drive(set5(1), set5(2), 0, 0, 0, 0, 0);
    expect_lk(0, 1, 1, 32'h1001, "R9"); expect_lk(1, 1, 1, 32'h1002, "R9"); commit();
    drive(set5(3), set5(4), 0, 0, 0, 0, 0);
    expect_lk(0, 1, 1, 32'h1003, "R9"); expect_lk(1, 1, 1, 32'h1004, "R9"); commit();
    step(a, b, 1, set5(5), 1, 32'h1005, 0);
    drive(set5(1), set5(5), 0, 0, 0, 0, 0);
    expect_lk(0, 0, 0, 0, "R10 victim way0"); expect_lk(1, 1, 1, 32'h1005, "R10"); commit();
    step(a, b, 1, set5(2), 1, 32'h2002, 0);
    step(a, b, 1, set5(6), 1, 32'h1006, 0);
    drive(set5(3), set5(2), 0, 0, 0, 0, 0);
    expect_lk(0, 0, 0, 0, "R10 victim way2"); expect_lk(1, 1, 1, 32'h2002, "R10"); commit();

    // R11: flush beats a same-cycle allocation
    drive(set5(6), a, 1, b, 1, t1, 1); expect_lk(0, 1, 1, 32'h1006, "R13 flush"); commit();
    drive(set5(6), b, 0, 0, 0, 0, 0);
    expect_lk(0, 0, 0, 0, "R11"); expect_lk(1, 0, 0, 0, "R11 priority"); commit();

    // random traffic, both ports
    for (int i = 0; i < 4000; i++) begin
      logic [31:0] p0, p1, up;
      p0 = {21'd0, 3'($urandom % 6), 6'($urandom % 3), 2'($urandom % 4)};
      p1 = {21'd0, 3'($urandom % 6), 6'($urandom % 3), 2'($urandom % 4)};
      up = {21'd0, 3'($urandom % 6), 6'($urandom % 3), 2'($urandom % 4)};
      step(p0, p1, ($urandom % 10) < 7, up, ($urandom % 10) < 6, $urandom,
           ($urandom % 100) == 0);
    end

    // R12: asynchronous reset mid-cycle
    step(a, a, 1, a, 1, t1, 0);
    @(negedge clk); upd_valid = 0; lk_pc[0] = a; lk_pc[1] = a;
    #2 rst_n = 0;
    #1 expect_lk(0, 0, 0, 0, "R12 async"); expect_lk(1, 0, 0, 0, "R12 async");
    m_clear();
    @(negedge clk); rst_n = 1;
    step(a, b, 0, 0, 0, 0, 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule